// File: doc/BRIEF.md
# Multi-Channel FIFO Communication Memory Controller

This block owns one processor's on-chip communication memory and presents it as a set of independent FIFO channels packed into one shared RAM. There are three access paths. The owning processor pushes words through a local write port. Remote processors pop words through a crossbar read port. An external-memory DMA engine acts as master on a third port, and it can either pop or push. The block keeps a write pointer and a read pointer for each channel, each with an extra wrap bit. Processes synchronise only by stalling: a push into a full channel waits, and a pop from an empty channel waits. No pointer ever needs arbitration.

The RAM is dual-ported. The processor has port A to itself. The crossbar and the DMA engine share port B under a fixed rule: while the DMA engine asserts its valid, it owns port B. Each channel has exactly one producer, chosen by the parameter `DMA_FILL`. A clear bit gives the channel to the processor, which fills the outbound staging FIFOs. A set bit gives it to the DMA engine, which fills the inbound staging FIFOs. Every channel has `DEPTH` words, and channel c occupies RAM words c*DEPTH through c*DEPTH+DEPTH-1.

All request interfaces use valid/ready. A request completes on a rising clock edge where valid and ready are both high. Ready depends only on the channel selected and the pointer state, and never on valid (port B also depends on `dma_valid`). A requester that sees ready low must keep valid, channel and data steady until ready rises. Read responses cannot be back-pressured. The data arrives exactly one cycle after the accepting edge, and the requester must take it then.

Top module: `cmem_fifo_ctrl`

## Requirements
- R1: After reset every channel is empty. `xb_req_ready` is 0 and a DMA pop is not ready on every channel. `pw_ready` is 1 for every channel whose `DMA_FILL` bit is 0.
- R2: Single producer per channel. `pw_ready` is 0 for a channel whose `DMA_FILL` bit is 1. For a DMA push (`dma_write`=1), `dma_ready` is 0 on a channel whose `DMA_FILL` bit is 0.
- R3: After DEPTH pushes to a channel with no pop, the producer's ready for that channel is 0. It stays 0 until a pop from that channel. A push held during the stall is then accepted, and no earlier word is lost.
- R4: While a channel is empty, pop ready for that channel is 0 on both the crossbar port and the DMA port (`dma_write`=0). It stays 0 until a push to that channel.
- R5: Each channel returns words in the order they were pushed. Traffic on one channel never reorders or changes the data of another channel.
- R6: A processor push and a DMA access (pop or push) on different channels can both be accepted on the same clock edge.
- R7: While `dma_valid` is 1, `xb_req_ready` is 0, whatever the channel state.
- R8: A pop accepted on an edge drives the response valid (`xb_rsp_valid` or `dma_rsp_valid`) high in the following cycle, together with the popped word.
- R9: A word pushed by the DMA engine into a DMA-filled channel is later returned by a crossbar pop of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_valid | input | 1 | Processor push request |
| pw_ready | output | 1 | Processor push can complete this cycle |
| pw_chan | input | CW | Channel for the processor push |
| pw_data | input | DW | Word to push |
| xb_req_valid | input | 1 | Crossbar pop request |
| xb_req_ready | output | 1 | Crossbar pop can complete this cycle |
| xb_req_chan | input | CW | Channel for the crossbar pop |
| xb_rsp_valid | output | 1 | Crossbar response word present |
| xb_rsp_data | output | DW | Popped word for the crossbar |
| dma_valid | input | 1 | DMA request; while high, DMA owns port B |
| dma_ready | output | 1 | DMA request can complete this cycle |
| dma_write | input | 1 | 1 = DMA push, 0 = DMA pop |
| dma_chan | input | CW | Channel for the DMA request |
| dma_wdata | input | DW | Word for a DMA push |
| dma_rsp_valid | output | 1 | DMA pop response present |
| dma_rdata | output | DW | Popped word for the DMA engine |

## Verification
A wrong pointer or wrap bit shows up at the ports on the very next access to that channel. The wrong symptom appears on that access: a ready that rises when the channel is full or empty, a ready that never rises, or a response word out of push order. A slot address that mixes up channels corrupts a word that appears when its owning channel is popped. Because every slot is eventually drained in order, the corruption surfaces within DEPTH pops. A wrong port-B priority appears in the same cycle as a crossbar ready that is high while the DMA engine holds valid.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    PB_IDLE   = 2'd0,
    PB_XB_RD  = 2'd1,
    PB_DMA_RD = 2'd2,
    PB_DMA_WR = 2'd3
  } portb_op_e;
endpackage

// File: rtl/cmc_chan.sv
module cmc_chan #(
  parameter int DEPTH = 4,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wslot,
  output logic [PW-1:0] rslot,
  output logic          full,
  output logic          empty
);
  logic [PW:0] wp, rp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  assign wslot = wp[PW-1:0];
  assign rslot = rp[PW-1:0];
  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);

  // R3: no push lands on a full channel
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R3: full persists until a pop
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  // R4: no pop from an empty channel
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R4: empty persists until a push
  a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: rtl/cmc_ram.sv
module cmc_ram #(
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_en && b_we) mem[b_addr] <= b_wdata;
    if (b_en && !b_we) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/cmc_portb.sv
module cmc_portb
  import cmc_pkg::*;
#(
  parameter int               NCH      = 4,
  parameter int               CW       = $clog2(NCH),
  parameter logic [NCH-1:0]   DMA_FILL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dma_valid,
  input  logic           dma_write,
  input  logic [CW-1:0]  dma_chan,
  input  logic           xb_valid,
  input  logic [CW-1:0]  xb_chan,
  input  logic [NCH-1:0] full,
  input  logic [NCH-1:0] empty,
  output logic           dma_ready,
  output logic           xb_ready,
  output portb_op_e      op,
  output logic [CW-1:0]  sel_chan
);
  always_comb begin
    if (dma_write) dma_ready = DMA_FILL[dma_chan] && !full[dma_chan];
    else           dma_ready = !empty[dma_chan];
    xb_ready = !dma_valid && !empty[xb_chan];
    op       = PB_IDLE;
    sel_chan = xb_chan;
    if (dma_valid && dma_ready) begin
      op       = dma_write ? PB_DMA_WR : PB_DMA_RD;
      sel_chan = dma_chan;
    end else if (xb_valid && xb_ready) begin
      op = PB_XB_RD;
    end
  end

  // R7: the crossbar never gets port B while the DMA engine holds valid
  a_r7_dma_owns_b: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> (op != PB_XB_RD));
  // R2: DMA pushes only reach DMA-filled channels
  a_r2_dma_push_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PB_DMA_WR) |-> DMA_FILL[sel_chan]);
endmodule

// File: rtl/cmem_fifo_ctrl.sv
module cmem_fifo_ctrl
  import cmc_pkg::*;
#(
  parameter int             NCH      = 4,
  parameter int             DEPTH    = 4,
  parameter int             DW       = 16,
  parameter logic [NCH-1:0] DMA_FILL = 4'b1000,
  parameter int             CW       = $clog2(NCH),
  parameter int             PW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pw_valid,
  output logic          pw_ready,
  input  logic [CW-1:0] pw_chan,
  input  logic [DW-1:0] pw_data,
  input  logic          xb_req_valid,
  output logic          xb_req_ready,
  input  logic [CW-1:0] xb_req_chan,
  output logic          xb_rsp_valid,
  output logic [DW-1:0] xb_rsp_data,
  input  logic          dma_valid,
  output logic          dma_ready,
  input  logic          dma_write,
  input  logic [CW-1:0] dma_chan,
  input  logic [DW-1:0] dma_wdata,
  output logic          dma_rsp_valid,
  output logic [DW-1:0] dma_rdata
);
  localparam int AW = CW + PW;

  logic [NCH-1:0]         push, pop, full, empty;
  logic [NCH-1:0][PW-1:0] wslot, rslot;
  portb_op_e              op;
  logic [CW-1:0]          b_chan;
  logic                   pw_fire;
  logic [AW-1:0]          a_addr, b_addr;
  logic [DW-1:0]          b_rdata;

  assign pw_ready = !DMA_FILL[pw_chan] && !full[pw_chan];
  assign pw_fire  = pw_valid && pw_ready;

  cmc_portb #(.NCH(NCH), .CW(CW), .DMA_FILL(DMA_FILL)) u_portb (
    .clk(clk), .rst_n(rst_n),
    .dma_valid(dma_valid), .dma_write(dma_write), .dma_chan(dma_chan),
    .xb_valid(xb_req_valid), .xb_chan(xb_req_chan),
    .full(full), .empty(empty),
    .dma_ready(dma_ready), .xb_ready(xb_req_ready),
    .op(op), .sel_chan(b_chan)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign push[c] = (pw_fire && pw_chan == CW'(c)) ||
                     (op == PB_DMA_WR && b_chan == CW'(c));
    assign pop[c]  = (op == PB_XB_RD || op == PB_DMA_RD) && b_chan == CW'(c);

    cmc_chan #(.DEPTH(DEPTH), .PW(PW)) u_chan (
      .clk(clk), .rst_n(rst_n), .push(push[c]), .pop(pop[c]),
      .wslot(wslot[c]), .rslot(rslot[c]), .full(full[c]), .empty(empty[c])
    );

    // R2: at most one producer may advance a channel in any cycle
    a_r2_one_producer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pw_fire && pw_chan == CW'(c), op == PB_DMA_WR && b_chan == CW'(c)}));
  end

  assign a_addr = {pw_chan, wslot[pw_chan]};
  assign b_addr = {b_chan, (op == PB_DMA_WR) ? wslot[b_chan] : rslot[b_chan]};

  cmc_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk),
    .a_we(pw_fire), .a_addr(a_addr), .a_wdata(pw_data),
    .b_en(op != PB_IDLE), .b_we(op == PB_DMA_WR),
    .b_addr(b_addr), .b_wdata(dma_wdata), .b_rdata(b_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xb_rsp_valid  <= 1'b0;
      dma_rsp_valid <= 1'b0;
    end else begin
      xb_rsp_valid  <= (op == PB_XB_RD);
      dma_rsp_valid <= (op == PB_DMA_RD);
    end
  end

  assign xb_rsp_data = b_rdata;
  assign dma_rdata   = b_rdata;

  // R8: an accepted crossbar pop answers in the next cycle
  a_r8_xb_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (xb_req_valid && xb_req_ready) |=> xb_rsp_valid);
  // R8: an accepted DMA pop answers in the next cycle
  a_r8_dma_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_ready && !dma_write) |=> dma_rsp_valid);
  // R6: a processor push is never blocked by port-B traffic
  a_r6_port_a_free: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid && !DMA_FILL[pw_chan] && !full[pw_chan]) |-> pw_ready);
endmodule

// File: tb/cmem_fifo_ctrl_test.sv
module cmem_fifo_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic pw_valid = 0, xb_req_valid = 0, dma_valid = 0, dma_write = 0;
  logic [1:0] pw_chan = 0, xb_req_chan = 0, dma_chan = 0;
  logic [15:0] pw_data = 0, dma_wdata = 0;
  logic pw_ready, xb_req_ready, xb_rsp_valid, dma_ready, dma_rsp_valid;
  logic [15:0] xb_rsp_data, dma_rdata;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [15:0] q0[$], q1[$], q2[$], q3[$];
  logic [15:0] xb_pend[$], dma_pend[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmem_fifo_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_chan(pw_chan), .pw_data(pw_data),
    .xb_req_valid(xb_req_valid), .xb_req_ready(xb_req_ready), .xb_req_chan(xb_req_chan),
    .xb_rsp_valid(xb_rsp_valid), .xb_rsp_data(xb_rsp_data),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_write(dma_write),
    .dma_chan(dma_chan), .dma_wdata(dma_wdata),
    .dma_rsp_valid(dma_rsp_valid), .dma_rdata(dma_rdata)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_push(int ch, logic [15:0] d);
    case (ch)
      0: q0.push_back(d);
      1: q1.push_back(d);
      2: q2.push_back(d);
      default: q3.push_back(d);
    endcase
  endtask

  function automatic logic [15:0] model_pop(int ch);
    case (ch)
      0: return q0.pop_front();
      1: return q1.pop_front();
      2: return q2.pop_front();
      default: return q3.pop_front();
    endcase
  endfunction

  task automatic proc_write(int ch, logic [15:0] d, output int fc);
    @(negedge clk);
    pw_valid = 1; pw_chan = 2'(ch); pw_data = d;
    #1;
    while (!pw_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    fc = cyc; pw_valid = 0;
    model_push(ch, d);
  endtask

  task automatic xb_read(int ch);
    @(negedge clk);
    xb_req_valid = 1; xb_req_chan = 2'(ch);
    #1;
    while (!xb_req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    xb_req_valid = 0;
    xb_pend.push_back(model_pop(ch));
    @(negedge clk);
    chk("R8 xb_rsp_valid after accept", int'(xb_rsp_valid), 1);
  endtask

  task automatic dma_op(bit wr, int ch, logic [15:0] d, output int fc);
    @(negedge clk);
    dma_valid = 1; dma_write = wr; dma_chan = 2'(ch); dma_wdata = d;
    #1;
    while (!dma_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    fc = cyc; dma_valid = 0; dma_write = 0;
    if (wr) model_push(ch, d);
    else    dma_pend.push_back(model_pop(ch));
  endtask

  // scoreboard monitor: R5 order, R8 data timing, R9 DMA-filled data
  always @(negedge clk) begin
    if (rst_n) begin
      if (xb_rsp_valid) begin
        if (xb_pend.size() == 0) chk("R8 unexpected xb response", 1, 0);
        else chk("R5 xb data order", int'(xb_rsp_data), int'(xb_pend.pop_front()));
      end
      if (dma_rsp_valid) begin
        if (dma_pend.size() == 0) chk("R8 unexpected dma response", 1, 0);
        else chk("R5 dma data order", int'(dma_rdata), int'(dma_pend.pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int fa, fb;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    @(negedge clk); #1;
    for (int c = 0; c < 3; c++) begin
      pw_chan = 2'(c); xb_req_chan = 2'(c); dma_chan = 2'(c); dma_write = 0; #1;
      chk("R1 pw_ready on processor channel", int'(pw_ready), 1);
      chk("R1 xb_req_ready empty", int'(xb_req_ready), 0);
      chk("R1 dma pop ready empty", int'(dma_ready), 0);
    end
    // R2: single producer
    pw_chan = 3; #1;
    chk("R2 pw_ready on DMA-filled channel", int'(pw_ready), 0);
    dma_write = 1; dma_chan = 0; #1;
    chk("R2 dma push on processor channel", int'(dma_ready), 0);
    dma_chan = 3; #1;
    chk("R2 dma push on DMA-filled channel", int'(dma_ready), 1);
    dma_write = 0; pw_chan = 0;

    // R5: interleaved traffic on three channels
    for (int i = 0; i < 3; i++) begin
      proc_write(0, 16'(100 + i), fa);
      proc_write(1, 16'(200 + i), fa);
      proc_write(2, 16'(300 + i), fa);
    end
    xb_read(1); xb_read(0); xb_read(2); xb_read(0);
    proc_write(1, 16'd210, fa);
    xb_read(2); xb_read(1); xb_read(0); xb_read(1); xb_read(2); xb_read(1);

    // R4: pop stalls on empty channel 2 until a push
    @(negedge clk);
    xb_req_valid = 1; xb_req_chan = 2; dma_chan = 2; dma_write = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R4 xb_req_ready held low on empty", int'(xb_req_ready), 0);
      chk("R4 dma pop ready low on empty", int'(dma_ready), 0);
    end
    xb_req_valid = 0;
    proc_write(2, 16'd77, fa);
    xb_read(2);

    // R3: push stalls on full channel 1 until a pop
    for (int i = 0; i < 4; i++) proc_write(1, 16'(400 + i), fa);
    @(negedge clk);
    pw_valid = 1; pw_chan = 1; pw_data = 16'd999;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R3 pw_ready held low on full", int'(pw_ready), 0);
    end
    pw_valid = 0;
    fork
      proc_write(1, 16'd999, fa);
      begin repeat (2) @(negedge clk); xb_read(1); end
    join
    for (int i = 0; i < 4; i++) xb_read(1);

    // R7: DMA owns port B while valid
    proc_write(0, 16'd501, fa);
    proc_write(0, 16'd502, fa);
    @(negedge clk);
    dma_valid = 1; dma_write = 0; dma_chan = 0;
    xb_req_valid = 1; xb_req_chan = 0; #1;
    chk("R7 xb_req_ready low while dma_valid", int'(xb_req_ready), 0);
    chk("R7 dma pop ready", int'(dma_ready), 1);
    @(posedge clk); #1;
    dma_valid = 0; xb_req_valid = 0;
    dma_pend.push_back(model_pop(0));
    xb_read(0);

    // R6: same-cycle processor push and DMA access
    proc_write(0, 16'd600, fa);
    fork
      proc_write(0, 16'd601, fa);
      dma_op(0, 0, 16'd0, fb);
    join
    chk("R6 push and dma pop same edge", fa, fb);
    fork
      proc_write(2, 16'd700, fa);
      dma_op(1, 3, 16'd800, fb);
    join
    chk("R6 push and dma push same edge", fa, fb);

    // R9: DMA-filled channel read through the crossbar
    dma_op(1, 3, 16'd801, fa);
    xb_read(3); xb_read(3); xb_read(0); xb_read(2);

    repeat (3) @(negedge clk);
    chk("R5 xb scoreboard drained", xb_pend.size(), 0);
    chk("R5 dma scoreboard drained", dma_pend.size(), 0);
    chk("R9 channel 3 model empty", q3.size(), 0);
    finish_run();
  end
endmodule